// File: doc/BRIEF.md
# Programmable DRAM access sequencer

This block runs one bank of asynchronous DRAM, either fast-page-mode or EDO, from a plain request port. A requester raises `req_valid` with a direction, a word address and write data, and holds them until `req_ready` pulses. The block splits the address into a row and a column, multiplexes them onto one address bus, and drives the row strobe, the column strobe, the write enable and the data bus through counted phases: row activate, column strobe, column precharge and row precharge.

All timing and geometry comes from one 32-bit control word read at run time. It holds the memory type, the length of every phase, the column width, and a base and a limit pointer that are compared against the top address bits. A request that does not fall inside the window is ignored. The row stays open after an access so that a following access to the same row skips activation. An external refresh unit asks for the pins with `refresh_req`. The block closes any open row, waits out the row precharge, and then holds `refresh_gnt` for as long as the request stays high.

The control word must only be changed while no access is in progress. Its fields are:

| Bits | Meaning |
|---|---|
| 0 | memory type: 0 fast-page, 1 EDO |
| 2:1 | column strobe length, code+1 cycles |
| 3 | column precharge, code+1 cycles |
| 6:4 | reserved, write 001 |
| 7 | row-to-column delay, code+1 cycles |
| 9:8 | row precharge, code+1 cycles |
| 19:10 | window base |
| 29:20 | window limit |
| 31:30 | column bits, 8+code |

Top module: `dram_seq`

## Requirements
- R1: During and after synchronous reset, and until a request arrives, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `dram_dq_oe`, `req_ready` and `refresh_gnt` are 0.
- R2: A request is served only when the top 10 bits of `req_addr` are at or above the base (bits 19:10) and below the limit (bits 29:20). Any other request produces no row strobe and no `req_ready`.
- R3: When no row is open, an accepted request drives the row address and holds `dram_ras_n` low for bit 7 + 1 cycles before `dram_cas_n` falls. `dram_cas_n` is low only while `dram_ras_n` is low.
- R4: `dram_cas_n` stays low for bits[2:1] + 1 cycles, with the column on `dram_addr`. During a write strobe `dram_we_n` is 0 and `dram_dq_oe` is 1, with the write data on `dram_dq_out`. Neither is active outside a write strobe.
- R5: The column is the low 8 + bits[31:30] bits of the address, and the row is the next 11 bits.
- R6: With bit 0 = 0, read data is taken from `dram_dq_in` on the last cycle of the column strobe. With bit 0 = 1 it is taken on the first cycle after `dram_cas_n` rises, which adds one cycle to a read.
- R7: `req_ready` is high for exactly one cycle per access, with `req_rdata` valid for a read. Counting the cycle in which the request is first seen as 1, `req_ready` is high in cycle 1 + Trcd + Tcs (+1 for an EDO read) for a closed row. For a page hit it is 1 + Tcp + Tcs (+1), and for a row miss it is 1 + Trp + Trcd + Tcs (+1).
- R8: A request to the row already open keeps `dram_ras_n` low and waits bit 3 + 1 cycles of column precharge before the strobe.
- R9: A request to another row raises `dram_ras_n` for exactly bits[9:8] + 1 cycles before the new row is activated.
- R10: `refresh_req` beats new requests. `refresh_gnt` rises 1 + Trp cycles after it is seen with a row open, or 1 cycle after with none open. While granted, both strobes are high and no request is served. `refresh_gnt` falls one cycle after `refresh_req` falls.
- R11: Bits[6:4] of the control word have no effect on timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_word | input | 32 | packed mode, timing, geometry and window word |
| req_valid | input | 1 | request present, held until `req_ready` |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | word address |
| req_wdata | input | DATA_W | write data |
| req_ready | output | 1 | one-cycle completion pulse |
| req_rdata | output | DATA_W | read data, valid with `req_ready` |
| refresh_req | input | 1 | refresh unit asks for the pins |
| refresh_gnt | output | 1 | pins released to the refresh unit |
| dram_addr | output | RA_W | multiplexed row or column address |
| dram_ras_n | output | 1 | row strobe, active low |
| dram_cas_n | output | 1 | column strobe, active low |
| dram_we_n | output | 1 | write enable, active low |
| dram_dq_out | output | DATA_W | data driven to memory |
| dram_dq_oe | output | 1 | data bus drive enable |
| dram_dq_in | input | DATA_W | data returned by memory |

## Verification
The memory model returns a poison value outside the window in which each memory type is valid. A fast-page read that samples late therefore fails, and so does an EDO read that samples early. Access sequences cover a closed row, a hit on the open row and a miss to another row, which tell apart the three latency formulas and show whether the row strobe stays low or precharges for the programmed time. Column widths of 8, 10 and 11 bits separate the row/column split. Addresses just below the base, at the limit, at the base and just below the limit test the window edges. Refresh is requested with a row open, from idle, and with a competing request, which shows the precharge wait, the hold and the priority. Two control words that differ only in the reserved bits must behave the same.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int CFG_W = 32;
  localparam int PTR_W = 10;
  localparam int CNT_W = 2;
  localparam int CB_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_STROBE, ST_EDO, ST_DONE,
    ST_OPEN, ST_CPRE, ST_RPRE, ST_REF
  } seq_state_e;

  // timing fields hold cycle count minus one
  typedef struct packed {
    logic             edo;
    logic [CNT_W-1:0] t_act;
    logic [CNT_W-1:0] t_strobe;
    logic [CNT_W-1:0] t_cpre;
    logic [CNT_W-1:0] t_rpre;
    logic [CB_W-1:0]  col_bits;
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] lim;
  } seq_cfg_t;

endpackage

// File: rtl/dram_cfg_unpack.sv
module dram_cfg_unpack
  import dram_seq_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output seq_cfg_t         cfg
);

  logic unused_rsv;
  assign unused_rsv = ^cfg_word[6:4];

  always_comb begin
    cfg.edo      = cfg_word[0];
    cfg.t_strobe = cfg_word[2:1];
    cfg.t_cpre   = {1'b0, cfg_word[3]};
    cfg.t_act    = {1'b0, cfg_word[7]};
    cfg.t_rpre   = cfg_word[9:8];
    cfg.base     = cfg_word[19:10];
    cfg.lim      = cfg_word[29:20];
    cfg.col_bits = CB_W'(8) + {2'b00, cfg_word[31:30]};
  end

endmodule

// File: rtl/dram_row_col_split.sv
module dram_row_col_split #(
  parameter int ADDR_W = 24,
  parameter int RA_W   = 11,
  parameter int CB_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CB_W-1:0]   col_bits,
  output logic [RA_W-1:0]   row,
  output logic [RA_W-1:0]   col
);

  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] low;

  assign shifted = addr >> col_bits;
  assign mask    = ~({ADDR_W{1'b1}} << col_bits);
  assign low     = addr & mask;
  assign row     = shifted[RA_W-1:0];
  assign col     = low[RA_W-1:0];

endmodule

// File: rtl/dram_range_hit.sv
module dram_range_hit #(
  parameter int PTR_W = 10
) (
  input  logic [PTR_W-1:0] top,
  input  logic [PTR_W-1:0] base,
  input  logic [PTR_W-1:0] lim,
  output logic             hit
);

  assign hit = (top >= base) && (top < lim);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int RA_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  input  logic              refresh_req,
  output logic              refresh_gnt,
  output logic [RA_W-1:0]   dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  seq_cfg_t cfg;
  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic wr_q, pend_q, pend_d, take, req_hit;
  logic [RA_W-1:0] req_row, req_col, cur_row, cur_col;
  logic ras_on_d;

  dram_cfg_unpack u_cfg (.cfg_word(cfg_word), .cfg(cfg));

  dram_range_hit #(.PTR_W(PTR_W)) u_hit (
    .top(req_addr[ADDR_W-1 -: PTR_W]), .base(cfg.base), .lim(cfg.lim), .hit(req_hit)
  );

  dram_row_col_split #(.ADDR_W(ADDR_W), .RA_W(RA_W), .CB_W(CB_W)) u_split_req (
    .addr(req_addr), .col_bits(cfg.col_bits), .row(req_row), .col(req_col)
  );

  dram_row_col_split #(.ADDR_W(ADDR_W), .RA_W(RA_W), .CB_W(CB_W)) u_split_cur (
    .addr(addr_q), .col_bits(cfg.col_bits), .row(cur_row), .col(cur_col)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    pend_d  = pend_q;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (refresh_req) begin
          state_d = ST_REF;
        end else if (req_valid && req_hit) begin
          take = 1'b1; state_d = ST_ACT; cnt_d = cfg.t_act;
        end
      end
      ST_ACT: if (cnt_q == '0) begin state_d = ST_STROBE; cnt_d = cfg.t_strobe; end
      ST_STROBE: if (cnt_q == '0) state_d = (cfg.edo && !wr_q) ? ST_EDO : ST_DONE;
      ST_EDO:  state_d = ST_DONE;
      ST_DONE: state_d = ST_OPEN;
      ST_OPEN: begin
        if (refresh_req) begin
          state_d = ST_RPRE; cnt_d = cfg.t_rpre;
        end else if (req_valid && req_hit) begin
          take = 1'b1;
          if (req_row == cur_row) begin
            state_d = ST_CPRE; cnt_d = cfg.t_cpre;
          end else begin
            state_d = ST_RPRE; cnt_d = cfg.t_rpre; pend_d = 1'b1;
          end
        end
      end
      ST_CPRE: if (cnt_q == '0) begin state_d = ST_STROBE; cnt_d = cfg.t_strobe; end
      ST_RPRE: begin
        if (cnt_q == '0) begin
          if (pend_q) begin
            state_d = ST_ACT; cnt_d = cfg.t_act; pend_d = 1'b0;
          end else if (refresh_req) begin
            state_d = ST_REF;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_REF:  if (!refresh_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ras_on_d = (state_d == ST_ACT) || (state_d == ST_STROBE) || (state_d == ST_EDO) ||
                    (state_d == ST_DONE) || (state_d == ST_OPEN) || (state_d == ST_CPRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      dram_addr   <= '0;
      req_ready   <= 1'b0;
      req_rdata   <= '0;
      refresh_gnt <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      if (take) begin
        addr_q      <= req_addr;
        wr_q        <= req_write;
        dram_dq_out <= req_wdata;
      end
      dram_ras_n  <= !ras_on_d;
      dram_cas_n  <= !(state_d == ST_STROBE);
      dram_we_n   <= !((state_d == ST_STROBE) && wr_q);
      dram_dq_oe  <= (state_d == ST_STROBE) && wr_q;
      if (state_d == ST_ACT) dram_addr <= take ? req_row : cur_row;
      else                   dram_addr <= take ? req_col : cur_col;
      req_ready   <= (state_d == ST_DONE);
      refresh_gnt <= (state_d == ST_REF);
      if ((state_q == ST_STROBE && cnt_q == '0 && !cfg.edo && !wr_q) || (state_q == ST_EDO))
        req_rdata <= dram_dq_in;
    end
  end

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_word,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic        dq_oe,
  input logic        ready,
  input logic        gnt
);

  logic [2:0] hi_cnt, lo_cnt, trp_len, tcs_len;
  logic unused_cfg;

  assign unused_cfg = ^{cfg_word[31:10], cfg_word[7:3], cfg_word[0]};
  assign trp_len = {1'b0, cfg_word[9:8]} + 3'd1;
  assign tcs_len = {1'b0, cfg_word[2:1]} + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 3'd7;
      lo_cnt <= 3'd0;
    end else begin
      hi_cnt <= ras_n ? ((hi_cnt == 3'd7) ? 3'd7 : hi_cnt + 3'd1) : 3'd0;
      lo_cnt <= !cas_n ? ((lo_cnt == 3'd7) ? 3'd7 : lo_cnt + 3'd1) : 3'd0;
    end
  end

  p_cas_in_row_r3: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n);
  p_strobe_len_r4: assert property (@(posedge clk) disable iff (rst) $rose(cas_n) |-> lo_cnt == tcs_len);
  p_we_in_strobe_r4: assert property (@(posedge clk) disable iff (rst) !we_n |-> !cas_n);
  p_oe_write_r4: assert property (@(posedge clk) disable iff (rst) dq_oe |-> !we_n);
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst) ready |=> !ready);
  p_row_precharge_r9: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |-> hi_cnt >= trp_len);
  p_gnt_idle_pins_r10: assert property (@(posedge clk) disable iff (rst) gnt |-> (ras_n && cas_n));

endmodule

bind dram_seq dram_seq_chk u_dram_seq_chk (
  .clk(clk), .rst(rst), .cfg_word(cfg_word), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .ready(req_ready), .gnt(refresh_gnt)
);

// File: tb/dram_seq_bench.sv
module dram_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int RA_W = 11;

  logic clk = 0, rst = 1;
  logic [31:0] cfg_word = '0;
  logic req_valid = 0, req_write = 0, refresh_req = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, refresh_gnt, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DATA_W-1:0] req_rdata, dram_dq_out, dram_dq_in;
  logic [RA_W-1:0] dram_addr;

  int checks = 0, errors = 0;
  logic bench_edo = 0;
  logic [15:0] mem [256];
  logic [15:0] edo_q = '0;
  logic [RA_W-1:0] last_row = '0, last_col = '0;
  int last_rpre = 0, last_strobe = 0, ras_hi = 0, cas_lo = 0, n_ras_fall = 0, n_ready = 0;
  logic prev_ras = 1, prev_cas = 1;
  logic [7:0] idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RA_W(RA_W)) u_dram_seq (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .refresh_req(refresh_req), .refresh_gnt(refresh_gnt), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // memory model: fast-page data valid only during the strobe, EDO data only after it
  assign idx = {last_row[3:0], dram_addr[3:0]};
  always_comb begin
    if (!dram_cas_n) dram_dq_in = bench_edo ? 16'hBEEF : mem[idx];
    else             dram_dq_in = bench_edo ? edo_q : 16'hDEAD;
  end

  always @(negedge clk) begin
    if (!dram_ras_n && prev_ras) begin
      last_row = dram_addr; last_rpre = ras_hi; n_ras_fall++;
    end
    ras_hi = dram_ras_n ? ras_hi + 1 : 0;
    if (!dram_cas_n && prev_cas) begin last_col = dram_addr; cas_lo = 0; end
    if (!dram_cas_n) begin
      cas_lo++;
      if (!dram_we_n) mem[{last_row[3:0], dram_addr[3:0]}] = dram_dq_out;
      edo_q = mem[{last_row[3:0], dram_addr[3:0]}];
    end
    if (dram_cas_n && !prev_cas) last_strobe = cas_lo;
    if (req_ready) n_ready++;
    prev_ras = dram_ras_n; prev_cas = dram_cas_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int edo, tcs, tcp, trcd, trp, ncol,
                                         input logic [9:0] base, lim, input logic [2:0] rsv);
    return {ncol[1:0], lim, base, trp[1:0], trcd[0], rsv, tcp[0], tcs[1:0], edo[0]};
  endfunction

  task automatic access(input logic wr, input logic [23:0] a, input logic [15:0] d,
                        output int lat, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (req_ready) break;
    end
    rd = req_rdata; req_valid = 0;
    @(posedge clk); @(negedge clk);
    chk("R7 ready one cycle", {31'b0, req_ready}, 32'h0);
  endtask

  task automatic close_row(input int exp_lat);
    int lat = 0;
    @(negedge clk);
    refresh_req = 1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (refresh_gnt) break;
    end
    chk("R10 grant latency", lat, exp_lat);
    chk("R10 strobes high in grant", {30'b0, dram_ras_n, dram_cas_n}, 32'h3);
    refresh_req = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 grant released", {31'b0, refresh_gnt}, 32'h0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset pins", {26'b0, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, req_ready, refresh_gnt},
        32'h38);
  endtask

  // fast-page: closed-row write, page-hit write, page-hit read
  task automatic t_fpm_page;
    int lat; logic [15:0] rd; int falls;
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 0, 10'h010, 10'h020, 3'b001);
    access(1, 24'h041234, 16'hA5A5, lat, rd);
    chk("R7 closed-row latency", lat, 5);
    chk("R3 row address", last_row, 32'h412);
    chk("R5 column 8 bits", last_col, 32'h34);
    chk("R4 strobe length", last_strobe, 2);
    falls = n_ras_fall;
    access(1, 24'h041256, 16'h1111, lat, rd);
    chk("R8 page-hit write latency", lat, 5);
    access(0, 24'h041234, 16'h0, lat, rd);
    chk("R8 page-hit read latency", lat, 5);
    chk("R6 fast-page read data", rd, 32'hA5A5);
    chk("R8 row kept open", n_ras_fall - falls, 0);
    // row miss
    access(1, 24'h042238, 16'h7777, lat, rd);
    chk("R9 row-miss latency", lat, 8);
    chk("R9 row precharge cycles", last_rpre, 3);
    chk("R3 new row address", last_row, 32'h422);
    access(0, 24'h042238, 16'h0, lat, rd);
    chk("R6 read after miss", rd, 32'h7777);
    close_row(4);
  endtask

  task automatic t_edo;
    int lat; logic [15:0] rd;
    cfg_word = mk_cfg(1, 0, 0, 0, 0, 0, 10'h010, 10'h020, 3'b001);
    bench_edo = 1;
    access(1, 24'h050010, 16'hC3C3, lat, rd);
    chk("R7 EDO write latency", lat, 3);
    chk("R4 one-cycle strobe", last_strobe, 1);
    access(0, 24'h050010, 16'h0, lat, rd);
    chk("R6 EDO hit read latency", lat, 4);
    chk("R6 EDO read data", rd, 32'hC3C3);
    access(0, 24'h041234, 16'h0, lat, rd);
    chk("R6 EDO miss read latency", lat, 5);
    chk("R6 EDO miss data", rd, 32'hA5A5);
    close_row(2);
    bench_edo = 0;
  endtask

  task automatic t_split;
    int lat; logic [15:0] rd;
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 2, 10'h010, 10'h020, 3'b001);
    access(1, 24'h04ABCD, 16'h5A5A, lat, rd);
    chk("R5 row with 10 col bits", last_row, 32'h12A);
    chk("R5 col with 10 col bits", last_col, 32'h3CD);
    access(0, 24'h04ABCD, 16'h0, lat, rd);
    chk("R5 data with 10 col bits", rd, 32'h5A5A);
    close_row(4);
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 3, 10'h010, 10'h020, 3'b001);
    access(1, 24'h04ABCD, 16'h1234, lat, rd);
    chk("R5 row with 11 col bits", last_row, 32'h095);
    chk("R5 col with 11 col bits", last_col, 32'h3CD);
    close_row(4);
  endtask

  task automatic hold_ignored(input logic [23:0] a, input string tag);
    int f0 = n_ras_fall, r0 = n_ready;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    repeat (20) @(negedge clk);
    req_valid = 0;
    chk(tag, (n_ras_fall - f0) + (n_ready - r0), 0);
  endtask

  task automatic t_range;
    int lat; logic [15:0] rd;
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 0, 10'h010, 10'h020, 3'b001);
    hold_ignored(24'h03FFFF, "R2 below base ignored");
    hold_ignored(24'h080000, "R2 at limit ignored");
    access(0, 24'h040000, 16'h0, lat, rd);
    chk("R2 at base served", lat, 5);
    access(0, 24'h07FFFF, 16'h0, lat, rd);
    chk("R2 below limit served", lat, 8);
    close_row(4);
  endtask

  task automatic t_refresh_priority;
    int lat = 0, r0;
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 0, 10'h010, 10'h020, 3'b001);
    @(negedge clk);
    refresh_req = 1; req_valid = 1; req_write = 0; req_addr = 24'h041234;
    @(posedge clk); @(negedge clk);
    chk("R10 grant from idle", {31'b0, refresh_gnt}, 32'h1);
    r0 = n_ready;
    repeat (5) @(negedge clk);
    chk("R10 no access in grant", n_ready - r0, 0);
    refresh_req = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (req_ready) break;
    end
    req_valid = 0;
    chk("R10 request served after release", lat, 6);
    repeat (2) @(negedge clk);
    close_row(4);
  endtask

  task automatic t_reserved;
    int lat; logic [15:0] rd;
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 0, 10'h010, 10'h020, 3'b111);
    access(0, 24'h041234, 16'h0, lat, rd);
    chk("R11 reserved 111 latency", lat, 5);
    chk("R11 reserved 111 data", rd, 32'hA5A5);
    close_row(4);
    cfg_word = mk_cfg(0, 1, 1, 1, 2, 0, 10'h010, 10'h020, 3'b000);
    access(0, 24'h041234, 16'h0, lat, rd);
    chk("R11 reserved 000 latency", lat, 5);
    close_row(4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_fpm_page();
    t_edo();
    t_split();
    t_range();
    t_refresh_priority();
    t_reserved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule